// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block sits between rename and issue in an out-of-order core. It keeps one ready bit for every physical register and holds a small pool of waiting instructions. Each waiting instruction sits in a slot with up to a fixed number of source operands. When an instruction enters a slot, each source operand looks up the ready bits. A source whose register is already ready, or is being woken in the same cycle, is recorded as ready at once. Any other source waits for the register's producer to complete.

When a producer completes, its destination register is woken. The register's ready bit is set, and every waiting source that names the register is marked ready. The number of operands woken that cycle is reported. A slot whose sources are all ready raises its bit in a ready vector, which issue selection reads. Completions on registers with a fixed architectural mapping wake nothing. A pinned register may be written several times, so it wakes only on its last outstanding write. A squash drops every waiting slot younger than a given sequence number and clears the ready bits of those slots' destinations. A grant from issue selection frees a slot.

Top module: `rwk_wakeup`

## Requirements
- R1: After reset every physical register reads ready in `preg_ready`, `slot_ready` is all zero and `wake_count` is zero.
- R2: An inserted source is recorded ready if its register's ready bit is set; unused source positions count as ready. A slot whose sources are all ready shows a 1 in `slot_ready` from the cycle after insertion and keeps it until it is freed.
- R3: Inserting an instruction with a destination clears that register's `preg_ready` bit from the next cycle on.
- R4: A completion that wakes register r sets `preg_ready[r]` from the next cycle on. Every valid waiting source naming r becomes ready. In the completion cycle `wake_count` equals the number of such unready sources held in valid slots.
- R5: A completion with `cmp_fixed` high changes no ready bit and wakes no source, and `wake_count` is 0.
- R6: An insertion with destination r and `ins_pin_writes` = k > 0 makes r pinned. Each of the first k-1 later non-fixed completions of r only lowers the pending count: there is no wakeup and `wake_count` is 0. Completion number k wakes r as in R4.
- R7: A source inserted in the same cycle as a completion that wakes its register is recorded ready.
- R8: A squash frees every valid slot whose sequence number is greater (unsigned) than `sq_seq` and clears the ready bit of each such slot's destination. Older slots are kept.
- R9: A grant on `iss_valid`/`iss_slot` frees that slot, so its `slot_ready` bit is 0 from the next cycle on.
- R10: A slot with a valid source that is not yet ready keeps its `slot_ready` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_slot | input | SLW | Target slot, which must be free |
| ins_seq | input | SEQ_W | Sequence number (age) of the inserted instruction |
| ins_src_vld | input | NSRC | Per-source used flag, bit i for source i |
| ins_src_reg | input | NSRC*PW | Source registers, source i in bits [i*PW +: PW] |
| ins_dst_vld | input | 1 | Instruction writes a destination |
| ins_dst_reg | input | PW | Destination register |
| ins_pin_writes | input | PINW | Outstanding writes for a pinned destination, 0 when not pinned |
| cmp_valid | input | 1 | A producer completes this cycle |
| cmp_reg | input | PW | Completed destination register |
| cmp_fixed | input | 1 | Completed register has a fixed mapping, so no wakeup |
| iss_valid | input | 1 | Issue grant frees a slot |
| iss_slot | input | SLW | Granted slot |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Slots younger than this are dropped |
| slot_ready | output | NSLOT | Per-slot ready to issue |
| preg_ready | output | NPREG | Per-register ready bit |
| wake_count | output | WCW | Number of source operands woken this cycle |

## Verification
The bench builds the block with 8 physical registers, 4 slots, 3 sources per slot, a 16-bit sequence number and 2-bit pin counts. With so few registers, random completions often hit registers that waiting slots depend on. A single completion can therefore wake several sources across slots, and pinned counts of 1 to 3 are reached and run down. The 4-slot pool fills often, so grants, squashes at varying ages and same-cycle insert and completion collisions all occur during the random phase. Directed cases cover fixed mappings, pinned countdown, the insert-time race and squash clearing.

// File: rtl/rwk_pkg.sv
package rwk_pkg;

  // A register may wake when it is not pinned (0) or on its last pending write (1).
  function automatic logic rwk_may_wake(input int unsigned pending);
    return pending <= 1;
  endfunction

  // Population count of a small vector.
  function automatic int unsigned rwk_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/rwk_regstate.sv
module rwk_regstate #(
  parameter int NPREG = 32,
  parameter int PINW  = 2,
  localparam int PW   = $clog2(NPREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             cmp_fixed,
  input  logic [PW-1:0]    cmp_reg,
  input  logic             ins_en,
  input  logic [PW-1:0]    ins_reg,
  input  logic [PINW-1:0]  ins_pin,
  input  logic [NPREG-1:0] sq_clr,
  output logic [NPREG-1:0] rdy_q,
  output logic             wake_fire,
  output logic [PW-1:0]    wake_reg
);
  logic [PINW-1:0]  pin_q [NPREG];
  logic [PINW-1:0]  pin_cur;
  logic [NPREG-1:0] rdy_n;
  logic             cmp_live;

  assign pin_cur   = pin_q[cmp_reg];
  assign cmp_live  = cmp_valid && !cmp_fixed;
  assign wake_fire = cmp_live && rwk_pkg::rwk_may_wake(int'(pin_cur));
  assign wake_reg  = cmp_reg;

  always_comb begin
    rdy_n = rdy_q;
    if (wake_fire) rdy_n[wake_reg] = 1'b1;
    if (ins_en)    rdy_n[ins_reg]  = 1'b0;
    rdy_n = rdy_n & ~sq_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= '1;
      for (int r = 0; r < NPREG; r++) pin_q[r] <= '0;
    end else begin
      rdy_q <= rdy_n;
      if (cmp_live && pin_cur != '0) pin_q[cmp_reg] <= pin_cur - 1'b1;
      if (ins_en) pin_q[ins_reg] <= ins_pin;
    end
  end

  // R4: a woken register reads ready next cycle unless cleared in the same cycle
  a_r4_reg_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_fire && !(ins_en && ins_reg == wake_reg) && !sq_clr[wake_reg])
      |=> rdy_q[$past(wake_reg)]);

  // R6: a pinned register with writes left only counts down
  a_r6_pin_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_live && pin_cur > 1 && !(ins_en && ins_reg == cmp_reg))
      |=> pin_q[$past(cmp_reg)] == $past(pin_cur) - 1'b1);

  // R5: fixed-mapping completion never fires a wakeup
  a_r5_fixed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_fixed) |-> !wake_fire);

endmodule

// File: rtl/rwk_slot.sv
module rwk_slot #(
  parameter int NPREG = 32,
  parameter int NSRC  = 3,
  parameter int SEQ_W = 8,
  localparam int PW   = $clog2(NPREG),
  localparam int SCW  = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [NSRC-1:0]   ld_src_vld,
  input  logic [NSRC*PW-1:0] ld_src_reg,
  input  logic [NSRC-1:0]   ld_src_rdy,
  input  logic              ld_dst_vld,
  input  logic [PW-1:0]     ld_dst_reg,
  input  logic              issue_hit,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              wake_fire,
  input  logic [PW-1:0]     wake_reg,
  output logic              ready,
  output logic              sq_kill,
  output logic              dst_vld,
  output logic [PW-1:0]     dst_reg,
  output logic [SCW-1:0]    match_cnt
);
  logic             vld_q;
  logic [SEQ_W-1:0] seq_q;
  logic [NSRC-1:0]  sv_q, rd_q, hit;
  logic [PW-1:0]    sr_q [NSRC];
  logic             kill;

  assign sq_kill = sq_valid && vld_q && (seq_q > sq_seq);
  assign kill    = sq_kill || issue_hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = vld_q && sv_q[i] && !rd_q[i] && wake_fire && (sr_q[i] == wake_reg);

    // R4: a matched waiting source is ready next cycle
    a_r4_src_woken: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !load && !kill) |=> rd_q[i]);
    // R2: a ready source never drops back while the slot lives
    a_r2_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && rd_q[i] && !load && !kill) |=> rd_q[i]);
  end

  assign match_cnt = SCW'(rwk_pkg::rwk_ones(32'(hit)));
  assign ready     = vld_q && ((rd_q | ~sv_q) == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      seq_q   <= '0;
      sv_q    <= '0;
      rd_q    <= '0;
      dst_vld <= 1'b0;
      dst_reg <= '0;
      for (int i = 0; i < NSRC; i++) sr_q[i] <= '0;
    end else if (load) begin
      vld_q   <= 1'b1;
      seq_q   <= ld_seq;
      sv_q    <= ld_src_vld;
      rd_q    <= ld_src_rdy;
      dst_vld <= ld_dst_vld;
      dst_reg <= ld_dst_reg;
      for (int i = 0; i < NSRC; i++) sr_q[i] <= ld_src_reg[i*PW +: PW];
    end else if (kill) begin
      vld_q <= 1'b0;
    end else begin
      rd_q <= rd_q | hit;
    end
  end

  // R9: a granted slot is freed
  a_r9_grant_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hit && !load) |=> !ready);
  // R8: a squashed slot is freed
  a_r8_squash_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kill && !load) |=> !ready);

endmodule

// File: rtl/rwk_wakeup.sv
module rwk_wakeup #(
  parameter int NPREG = 32,
  parameter int NSLOT = 8,
  parameter int NSRC  = 3,
  parameter int SEQ_W = 8,
  parameter int PINW  = 2,
  localparam int PW   = $clog2(NPREG),
  localparam int SLW  = $clog2(NSLOT),
  localparam int SCW  = $clog2(NSRC + 1),
  localparam int WCW  = $clog2(NSLOT * NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  input  logic [SLW-1:0]     ins_slot,
  input  logic [SEQ_W-1:0]   ins_seq,
  input  logic [NSRC-1:0]    ins_src_vld,
  input  logic [NSRC*PW-1:0] ins_src_reg,
  input  logic               ins_dst_vld,
  input  logic [PW-1:0]      ins_dst_reg,
  input  logic [PINW-1:0]    ins_pin_writes,
  input  logic               cmp_valid,
  input  logic [PW-1:0]      cmp_reg,
  input  logic               cmp_fixed,
  input  logic               iss_valid,
  input  logic [SLW-1:0]     iss_slot,
  input  logic               sq_valid,
  input  logic [SEQ_W-1:0]   sq_seq,
  output logic [NSLOT-1:0]   slot_ready,
  output logic [NPREG-1:0]   preg_ready,
  output logic [WCW-1:0]     wake_count
);
  logic             wake_fire;
  logic [PW-1:0]    wake_reg;
  logic [NSRC-1:0]  ins_src_rdy;
  logic [NPREG-1:0] sq_clr;
  logic [NSLOT-1:0] slot_kill, slot_dv;
  logic [PW-1:0]    slot_dr  [NSLOT];
  logic [SCW-1:0]   slot_cnt [NSLOT];

  rwk_regstate #(.NPREG(NPREG), .PINW(PINW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_fixed(cmp_fixed), .cmp_reg(cmp_reg),
    .ins_en(ins_valid && ins_dst_vld), .ins_reg(ins_dst_reg), .ins_pin(ins_pin_writes),
    .sq_clr(sq_clr), .rdy_q(preg_ready), .wake_fire(wake_fire), .wake_reg(wake_reg)
  );

  // Insert-time lookup: ready bit, or a wakeup landing in this very cycle (R7).
  for (genvar i = 0; i < NSRC; i++) begin : g_look
    logic [PW-1:0] r;
    assign r = ins_src_reg[i*PW +: PW];
    assign ins_src_rdy[i] = !ins_src_vld[i] || preg_ready[r] || (wake_fire && wake_reg == r);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    rwk_slot #(.NPREG(NPREG), .NSRC(NSRC), .SEQ_W(SEQ_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(ins_valid && ins_slot == SLW'(s)),
      .ld_seq(ins_seq), .ld_src_vld(ins_src_vld), .ld_src_reg(ins_src_reg),
      .ld_src_rdy(ins_src_rdy), .ld_dst_vld(ins_dst_vld), .ld_dst_reg(ins_dst_reg),
      .issue_hit(iss_valid && iss_slot == SLW'(s)),
      .sq_valid(sq_valid), .sq_seq(sq_seq),
      .wake_fire(wake_fire), .wake_reg(wake_reg),
      .ready(slot_ready[s]), .sq_kill(slot_kill[s]),
      .dst_vld(slot_dv[s]), .dst_reg(slot_dr[s]), .match_cnt(slot_cnt[s])
    );
  end

  always_comb begin
    sq_clr     = '0;
    wake_count = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_kill[s] && slot_dv[s]) sq_clr[slot_dr[s]] = 1'b1;
      wake_count = wake_count + WCW'(slot_cnt[s]);
    end
  end

  // R5: a fixed completion alone leaves every ready bit untouched
  a_r5_fixed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_fixed && !ins_valid && !sq_valid) |=> $stable(preg_ready));
  // R5: and wakes no operand
  a_r5_fixed_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_fixed) |-> wake_count == '0);
  // R3: an inserted destination reads not ready next cycle
  a_r3_dst_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_dst_vld) |=> !preg_ready[$past(ins_dst_reg)]);

endmodule

// File: tb/rwk_wakeup_bench.sv
module rwk_wakeup_bench;
  localparam int NPREG = 8, NSLOT = 4, NSRC = 3, SEQ_W = 16, PINW = 2;
  localparam int PW = 3, SLW = 2, WCW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid, ins_dst_vld, cmp_valid, cmp_fixed, iss_valid, sq_valid;
  logic [SLW-1:0] ins_slot, iss_slot;
  logic [SEQ_W-1:0] ins_seq, sq_seq;
  logic [NSRC-1:0] ins_src_vld;
  logic [NSRC*PW-1:0] ins_src_reg;
  logic [PW-1:0] ins_dst_reg, cmp_reg;
  logic [PINW-1:0] ins_pin_writes;
  logic [NSLOT-1:0] slot_ready;
  logic [NPREG-1:0] preg_ready;
  logic [WCW-1:0] wake_count;

  always #4 clk = ~clk;

  rwk_wakeup #(.NPREG(NPREG), .NSLOT(NSLOT), .NSRC(NSRC), .SEQ_W(SEQ_W), .PINW(PINW)) u_rwk_wakeup (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_seq(ins_seq),
    .ins_src_vld(ins_src_vld), .ins_src_reg(ins_src_reg), .ins_dst_vld(ins_dst_vld),
    .ins_dst_reg(ins_dst_reg), .ins_pin_writes(ins_pin_writes), .cmp_valid(cmp_valid),
    .cmp_reg(cmp_reg), .cmp_fixed(cmp_fixed), .iss_valid(iss_valid), .iss_slot(iss_slot),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .slot_ready(slot_ready), .preg_ready(preg_ready),
    .wake_count(wake_count)
  );

  int vectors = 0, fails = 0, seq_ctr = 100;
  bit done = 0;

  // Reference state, kept from the requirements
  bit m_sb[NPREG]; int m_pin[NPREG];
  bit m_v[NSLOT]; int m_seq[NSLOT]; bit m_dv[NSLOT]; int m_dr[NSLOT];
  bit m_sv[NSLOT][NSRC]; int m_sr[NSLOT][NSRC]; bit m_rd[NSLOT][NSRC];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_fire();
    return cmp_valid && !cmp_fixed && m_pin[cmp_reg] <= 1;
  endfunction

  function automatic logic [31:0] m_wc();
    int n = 0;
    if (!m_fire()) return 0;
    for (int s = 0; s < NSLOT; s++)
      for (int i = 0; i < NSRC; i++)
        if (m_v[s] && m_sv[s][i] && !m_rd[s][i] && m_sr[s][i] == int'(cmp_reg)) n++;
    return n;
  endfunction

  function automatic logic [31:0] m_ready();
    logic [31:0] v = 0;
    for (int s = 0; s < NSLOT; s++) begin
      bit ok = m_v[s];
      for (int i = 0; i < NSRC; i++) if (m_sv[s][i] && !m_rd[s][i]) ok = 0;
      v[s] = ok;
    end
    return v;
  endfunction

  function automatic logic [31:0] m_regs();
    logic [31:0] v = 0;
    for (int r = 0; r < NPREG; r++) v[r] = m_sb[r];
    return v;
  endfunction

  task automatic m_update();
    bit fire = m_fire();
    bit sqk[NSLOT]; bit kill[NSLOT];
    bit sb_old[NPREG];
    for (int r = 0; r < NPREG; r++) sb_old[r] = m_sb[r];
    for (int s = 0; s < NSLOT; s++) begin
      sqk[s]  = sq_valid && m_v[s] && m_seq[s] > int'(sq_seq);
      kill[s] = sqk[s] || (iss_valid && int'(iss_slot) == s);
    end
    if (fire) m_sb[cmp_reg] = 1;
    if (ins_valid && ins_dst_vld) m_sb[ins_dst_reg] = 0;
    for (int s = 0; s < NSLOT; s++) if (sqk[s] && m_dv[s]) m_sb[m_dr[s]] = 0;
    if (cmp_valid && !cmp_fixed && m_pin[cmp_reg] > 0) m_pin[cmp_reg]--;
    if (ins_valid && ins_dst_vld) m_pin[ins_dst_reg] = int'(ins_pin_writes);
    for (int s = 0; s < NSLOT; s++) begin
      if (ins_valid && int'(ins_slot) == s) begin
        m_v[s] = 1; m_seq[s] = int'(ins_seq); m_dv[s] = ins_dst_vld; m_dr[s] = int'(ins_dst_reg);
        for (int i = 0; i < NSRC; i++) begin
          int r = int'(ins_src_reg[i*PW +: PW]);
          m_sv[s][i] = ins_src_vld[i]; m_sr[s][i] = r;
          m_rd[s][i] = !ins_src_vld[i] || sb_old[r] || (fire && r == int'(cmp_reg));
        end
      end else if (kill[s]) m_v[s] = 0;
      else if (m_v[s] && fire)
        for (int i = 0; i < NSRC; i++)
          if (m_sv[s][i] && m_sr[s][i] == int'(cmp_reg)) m_rd[s][i] = 1;
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_slot = 0; ins_seq = 0; ins_src_vld = 0; ins_src_reg = 0;
    ins_dst_vld = 0; ins_dst_reg = 0; ins_pin_writes = 0; cmp_valid = 0; cmp_reg = 0;
    cmp_fixed = 0; iss_valid = 0; iss_slot = 0; sq_valid = 0; sq_seq = 0;
  endtask

  // One clock: check the count before the edge, state after it.
  task automatic step(string req = "R4", int ewc = -1);
    #1;
    chk("R4 wake_count vs model", 32'(wake_count), m_wc());
    if (ewc >= 0) chk(req, 32'(wake_count), ewc);
    @(posedge clk);
    m_update();
    @(negedge clk);
    chk("R2 slot_ready vs model", 32'(slot_ready), m_ready());
    chk("R3 preg_ready vs model", 32'(preg_ready), m_regs());
    idle();
  endtask

  task automatic put(int slot, int seq, logic [2:0] sv, int r0, int r1, int r2,
                     bit dv, int dr, int pin);
    ins_valid = 1; ins_slot = SLW'(slot); ins_seq = SEQ_W'(seq); ins_src_vld = sv;
    ins_src_reg = {PW'(r2), PW'(r1), PW'(r0)};
    ins_dst_vld = dv; ins_dst_reg = PW'(dr); ins_pin_writes = PINW'(pin);
  endtask

  task automatic done_cmp(int r, bit fx); cmp_valid = 1; cmp_reg = PW'(r); cmp_fixed = fx; endtask
  task automatic grant(int s); iss_valid = 1; iss_slot = SLW'(s); endtask

  initial begin
    idle();
    for (int r = 0; r < NPREG; r++) begin m_sb[r] = 1; m_pin[r] = 0; end
    for (int s = 0; s < NSLOT; s++) begin m_v[s] = 0; m_dv[s] = 0; end
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 slot_ready", 32'(slot_ready), 0);
    chk("R1 preg_ready", 32'(preg_ready), 32'hff);
    chk("R1 wake_count", 32'(wake_count), 0);

    put(0, 10, 3'b001, 2, 0, 0, 1, 1, 0); step();
    chk("R2 ready with ready source", 32'(slot_ready[0]), 1);
    chk("R3 dst cleared", 32'(preg_ready[1]), 0);
    put(1, 11, 3'b011, 1, 1, 0, 1, 3, 0); step();
    chk("R10 waiting slot not ready", 32'(slot_ready[1]), 0);
    done_cmp(1, 0); step("R4 two sources woken", 2);
    chk("R4 consumer ready", 32'(slot_ready[1]), 1);
    chk("R4 reg ready", 32'(preg_ready[1]), 1);

    put(2, 12, 3'b001, 3, 0, 0, 0, 0, 0); step();
    done_cmp(3, 1); step("R5 fixed wakes none", 0);
    chk("R5 reg unchanged", 32'(preg_ready[3]), 0);
    chk("R5 consumer still waiting", 32'(slot_ready[2]), 0);
    done_cmp(3, 0); step("R4 single wake", 1);
    chk("R4 consumer ready", 32'(slot_ready[2]), 1);

    grant(0); step();
    chk("R9 grant frees slot", 32'(slot_ready[0]), 0);
    grant(1); step(); grant(2); step();

    put(3, 13, 3'b000, 0, 0, 0, 1, 4, 2); step();
    put(0, 14, 3'b001, 4, 0, 0, 0, 0, 0); step();
    done_cmp(4, 0); step("R6 first pinned write silent", 0);
    chk("R6 reg still pending", 32'(preg_ready[4]), 0);
    chk("R6 consumer still waiting", 32'(slot_ready[0]), 0);
    done_cmp(4, 0); step("R6 last pinned write wakes", 1);
    chk("R6 reg ready", 32'(preg_ready[4]), 1);
    chk("R6 consumer ready", 32'(slot_ready[0]), 1);

    grant(0); step(); grant(3); step();
    put(0, 20, 3'b000, 0, 0, 0, 1, 5, 0); step();
    put(1, 21, 3'b001, 5, 0, 0, 0, 0, 0); done_cmp(5, 0); step("R7 no stored waiter", 0);
    chk("R7 same-cycle source ready", 32'(slot_ready[1]), 1);

    grant(0); step(); grant(1); step();
    put(2, 30, 3'b000, 0, 0, 0, 1, 6, 0); step();
    put(3, 40, 3'b001, 6, 0, 0, 1, 7, 0); step();
    done_cmp(7, 0); step();
    chk("R4 reg set", 32'(preg_ready[7]), 1);
    sq_valid = 1; sq_seq = 30; step();
    chk("R8 squashed dst cleared", 32'(preg_ready[7]), 0);
    chk("R8 older slot kept", 32'(slot_ready[2]), 1);
    done_cmp(6, 0); step("R8 squashed waiter gone", 0);
    grant(2); step();
    seq_ctr = 100;

    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 100 < 40) done_cmp(int'($urandom % NPREG), ($urandom % 8) == 0);
      begin
        int s = int'($urandom % NSLOT);
        if (m_v[s] && ($urandom % 3) == 0) grant(s);
      end
      if (($urandom % 50) == 0) begin
        sq_valid = 1; sq_seq = SEQ_W'(seq_ctr - int'($urandom % 6));
      end else if ($urandom % 2 == 1) begin
        int st = int'($urandom % NSLOT);
        for (int k = 0; k < NSLOT; k++) begin
          int s = (st + k) % NSLOT;
          if (!m_v[s] && !(iss_valid && int'(iss_slot) == s) && !ins_valid) begin
            seq_ctr++;
            put(s, seq_ctr, 3'($urandom), int'($urandom % NPREG), int'($urandom % NPREG),
                int'($urandom % NPREG), ($urandom % 4) != 0, int'($urandom % NPREG),
                (($urandom % 5) == 0) ? int'(1 + $urandom % 3) : 0);
          end
        end
      end
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule